// File: doc/BRIEF.md
# Counter Overflow Interrupt Aggregator

This block merges the per-counter overflow flags of a performance-monitoring counter bank into one level-sensitive interrupt line. A counter can raise the interrupt only when four things hold for it at once: its overflow flag is set, it is enabled to count, its interrupt is enabled, and it is actually implemented. On top of that, the bank-wide enable must be set. The implemented set is described by a count field N. Counters 0 to N-1 are present. The dedicated cycle counter, which sits at the top bit of every vector, is always present.

The qualified status bits are OR-reduced and the result is registered. The interrupt line therefore changes one clock edge after the combined condition changes, and then holds that level for as long as the condition holds. A one-cycle change strobe goes high together with every rise and every fall of the line, so a downstream interrupt controller can react to the transition without comparing levels itself.

Top module: `ovf_irq_aggr`

## Requirements
- R1: While reset is high, and in the first cycle after it, the interrupt line and the change strobe are both 0.
- R2: Counter bit i contributes only when its overflow flag, counter-enable bit and interrupt-enable bit are all 1 in the same bit position. If any one of the three is 0, that bit cannot raise the line, even when other bits supply the missing enables.
- R3: When the global enable input is 0, the line goes to 0 on the next edge, whatever the vectors hold.
- R4: Bit 31 (the cycle counter) is always implemented. Bit i below 31 is implemented only when i < N, where N is the 5-bit count input. With N=0 only bit 31 can raise the line.
- R5: Once a qualifying bit appears, the line is 1 after the next rising clock edge. No other event is needed. The line stays 1 for as long as the condition persists (a level, not a pulse).
- R6: Removing the qualifying condition, by clearing the flag or an enable, drops the line after the next rising edge.
- R7: The change strobe is 1 for exactly the one cycle in which the line has just taken a new value. It is 0 while the line is steady.
- R8: Any single qualifying bit anywhere in the vector is enough to raise the line, including the highest event counter (bit 30 when N=31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ovf_flags_i | input | 32 | Per-counter overflow flags, bit 31 is the cycle counter |
| cnt_en_i | input | 32 | Per-counter counting enables |
| int_en_i | input | 32 | Per-counter interrupt enables |
| impl_n_i | input | 5 | Number of implemented event counters |
| glb_en_i | input | 1 | Bank-wide enable |
| irq_o | output | 1 | Registered interrupt level |
| irq_chg_o | output | 1 | One-cycle strobe on each level transition |

## Verification
The hardest case to reach from the ports is a bit that has its overflow flag and both enables set but is still rejected, because it lies just at or above N. The same holds for the cycle-counter bit, which must still pass when N is 0. The vector table places a single fully enabled flag at bit N, then at bit N-1, then at the cycle counter with N=0. It also splits the three qualifiers across different bit positions, so that only a per-bit AND leaves the line low. Directed steps then hold a condition over several cycles to show that the strobe stays low, and they apply reset while the line is high.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;

  // Number of event counters a given N enables, limited to what exists.
  function automatic int clamp_impl(input int n, input int cnt_max);
    return (n > cnt_max) ? cnt_max : n;
  endfunction

endpackage

// File: rtl/ovf_valid_mask.sv
module ovf_valid_mask #(
  parameter int CNT_MAX = 31,
  parameter int NW      = 5,
  localparam int VW     = CNT_MAX + 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NW-1:0] impl_n_i,
  output logic [VW-1:0] mask_o
);
  import ovf_irq_pkg::*;

  genvar i;
  generate
    for (i = 0; i < CNT_MAX; i++) begin : g_evt
      assign mask_o[i] = ({1'b0, impl_n_i} > (NW+1)'(i));
    end
  endgenerate

  // cycle counter always implemented
  assign mask_o[CNT_MAX] = 1'b1;

  // R4
  mask_pop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(mask_o) == clamp_impl(int'(impl_n_i), CNT_MAX) + 1);

endmodule

// File: rtl/ovf_status_combine.sv
module ovf_status_combine #(
  parameter int VW = 32
) (
  input  logic [VW-1:0] ovf_i,
  input  logic [VW-1:0] cen_i,
  input  logic [VW-1:0] ien_i,
  input  logic [VW-1:0] mask_i,
  input  logic          glb_i,
  output logic          any_o
);
  logic [VW-1:0] status;

  always_comb begin
    status = ovf_i & cen_i & ien_i & mask_i;
    if (!glb_i) status = '0;
    any_o = |status;
  end

endmodule

// File: rtl/ovf_level_reg.sv
module ovf_level_reg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic any_i,
  output logic irq_o,
  output logic chg_o
);
  import ovf_irq_pkg::*;

  lvl_e lvl_q;
  logic chg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q <= LVL_LOW;
      chg_q <= 1'b0;
    end else begin
      chg_q <= (any_i != lvl_q);
      if (any_i != lvl_q) lvl_q <= lvl_e'(any_i);
    end
  end

  assign irq_o = lvl_q;
  assign chg_o = chg_q;

  // R5
  level_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (irq_o == $past(any_i)));

  // R7
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    chg_o |-> (irq_o != $past(irq_o)));

  // R7
  steady_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o == $past(irq_o)) |-> !chg_o);

endmodule

// File: rtl/ovf_irq_aggr.sv
module ovf_irq_aggr #(
  parameter int CNT_MAX = 31,
  localparam int VW     = CNT_MAX + 1,
  localparam int NW     = $clog2(CNT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [VW-1:0] ovf_flags_i,
  input  logic [VW-1:0] cnt_en_i,
  input  logic [VW-1:0] int_en_i,
  input  logic [NW-1:0] impl_n_i,
  input  logic          glb_en_i,
  output logic          irq_o,
  output logic          irq_chg_o
);
  logic [VW-1:0] valid_mask;
  logic          any_hit;

  ovf_valid_mask #(.CNT_MAX(CNT_MAX), .NW(NW)) u_mask (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .impl_n_i (impl_n_i),
    .mask_o   (valid_mask)
  );

  ovf_status_combine #(.VW(VW)) u_comb (
    .ovf_i  (ovf_flags_i),
    .cen_i  (cnt_en_i),
    .ien_i  (int_en_i),
    .mask_i (valid_mask),
    .glb_i  (glb_en_i),
    .any_o  (any_hit)
  );

  ovf_level_reg u_lvl (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .any_i (any_hit),
    .irq_o (irq_o),
    .chg_o (irq_chg_o)
  );

  // R3
  glb_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !glb_en_i |=> !irq_o);

  // R2
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_o) |-> ($past(|(ovf_flags_i & cnt_en_i & int_en_i)) && $past(glb_en_i)));

  // R6
  clear_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((ovf_flags_i & cnt_en_i & int_en_i) == '0) |=> !irq_o);

endmodule

// File: tb/sim_ovf_irq_aggr.sv
`timescale 1ns/1ps
module sim_ovf_irq_aggr;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ovf, cen, ien;
  logic [4:0]  n;
  logic        glb;
  logic        irq, chg;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  always #10 clk = ~clk;

  ovf_irq_aggr u0 (
    .clk_i(clk), .rst_i(rst), .ovf_flags_i(ovf), .cnt_en_i(cen),
    .int_en_i(ien), .impl_n_i(n), .glb_en_i(glb),
    .irq_o(irq), .irq_chg_o(chg)
  );

  typedef struct packed {
    logic [31:0] ovf;
    logic [31:0] cen;
    logic [31:0] ien;
    logic [4:0]  n;
    logic        glb;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{32'h0,        32'h0,        32'h0,        5'd4,  1'b1, 1'b0, 8'd2}, // R2 idle
    '{32'h1,        32'h1,        32'h1,        5'd4,  1'b1, 1'b1, 8'd2}, // R2 all qualifiers
    '{32'h1,        32'h1,        32'h0,        5'd4,  1'b1, 1'b0, 8'd2}, // R2 no int enable
    '{32'h1,        32'h0,        32'h1,        5'd4,  1'b1, 1'b0, 8'd2}, // R2 no count enable
    '{32'h1,        32'h1,        32'h1,        5'd4,  1'b0, 1'b0, 8'd3}, // R3 global off
    '{32'h10,       32'h10,       32'h10,       5'd4,  1'b1, 1'b0, 8'd4}, // R4 bit 4, N=4
    '{32'h10,       32'h10,       32'h10,       5'd5,  1'b1, 1'b1, 8'd4}, // R4 bit 4, N=5
    '{32'h8000_0000,32'h8000_0000,32'h8000_0000,5'd0,  1'b1, 1'b1, 8'd4}, // R4 cycle, N=0
    '{32'h1,        32'h1,        32'h1,        5'd0,  1'b1, 1'b0, 8'd4}, // R4 bit 0, N=0
    '{32'h3,        32'h1,        32'h2,        5'd8,  1'b1, 1'b0, 8'd2}, // R2 split bits
    '{32'h4000_0000,32'hFFFF_FFFF,32'hFFFF_FFFF,5'd31, 1'b1, 1'b1, 8'd8}, // R8 bit 30
    '{32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,5'd31, 1'b0, 1'b0, 8'd3}, // R3 all set, off
    '{32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,5'd0,  1'b1, 1'b1, 8'd8}  // R8 many bits
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic prev;
    rst = 1'b1; ovf = '1; cen = '1; ien = '1; n = 5'd31; glb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 strobe in reset", chg, 1'b0);
    ovf = '0; cen = '0; ien = '0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 strobe after reset", chg, 1'b0);

    prev = 1'b0;
    for (int k = 0; k < NV; k++) begin
      ovf = TBL[k].ovf; cen = TBL[k].cen; ien = TBL[k].ien;
      n = TBL[k].n; glb = TBL[k].glb;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d level", TBL[k].req, k), irq, TBL[k].exp);
      chk($sformatf("R7 vec%0d strobe", k), chg, TBL[k].exp != prev);
      prev = TBL[k].exp;
    end

    // R5 and R7: hold condition; line stays, strobe quiet
    ovf = 32'h2; cen = 32'h2; ien = 32'h2; n = 5'd2; glb = 1'b1;
    @(negedge clk);
    chk("R5 hold first", irq, 1'b1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R5 hold level", irq, 1'b1);
      chk("R7 hold strobe", chg, 1'b0);
    end

    // R6: clear the flag, drop after one edge
    ovf = '0;
    @(negedge clk);
    chk("R6 drop on clear", irq, 1'b0);
    chk("R7 fall strobe", chg, 1'b1);
    @(negedge clk);
    chk("R7 strobe one cycle", chg, 1'b0);

    // R6: clearing an enable also drops the line
    ovf = 32'h2;
    @(negedge clk);
    chk("R5 re-raise", irq, 1'b1);
    ien = '0;
    @(negedge clk);
    chk("R6 drop on enable clear", irq, 1'b0);

    // R1: reset while line high
    ien = 32'h2;
    @(negedge clk);
    chk("R5 raise before reset", irq, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset while high", irq, 1'b0);
    chk("R1 strobe in reset high", chg, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 rise after reset", irq, 1'b1);

    finish_run();
  end

endmodule